// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block produces the single interrupt request of a real-time clock. It brings together three event sources: a periodic rate generator, the alarm-match pulse and the update-complete pulse. The periodic generator divides a 32.768 kHz timebase tick by a power of two, and a 4-bit rate code chooses which power. Each source sets a sticky flag whenever its event fires, whether or not that source is enabled.

Software reads the flags as one byte. Bit 7 of that byte is the summary request. It is set when at least one flag is set together with its enable. The active-low interrupt pin follows the summary bit. A read strobe clears every flag at the clock edge that ends the read. An event that arrives in the same cycle as the read is kept and is not lost.

The calendar counting, the alarm comparison and the register bus decoding are done outside this block. They reach it only as pulses and as level inputs.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While reset is held and directly after it, the flag byte reads 0x00 and the interrupt pin is high.
- R2: With rate code n from 3 to 15, the periodic flag is set by every 2^(n-1)-th timebase tick. The first such tick after reset is tick number 2^(n-1).
- R3: Rate code 1 gives a period of 128 ticks (256 Hz) and rate code 2 gives a period of 256 ticks (128 Hz).
- R4: Rate code 0 stops the periodic source, so the periodic flag is never set.
- R5: An alarm or update pulse sets its flag at the next clock edge, whatever the state of its enable.
- R6: Flag byte layout: bit 6 is periodic, bit 5 is alarm and bit 4 is update-complete. Bits 3 to 0 always read 0.
- R7: Bit 7 of the flag byte is the OR of (flag AND enable) over the three sources. The pin is the inverse of bit 7. Both follow a change of an enable in the same cycle.
- R8: A cycle with the read strobe high clears all flags at its closing edge, which releases the pin.
- R9: An event that arrives in the same cycle as a read is set in the flags after that read.
- R10: A flag that is set stays set until a read occurs.
- R11: The periodic divider advances only on cycles where the tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per timebase period (32.768 kHz) |
| update_done_i | input | 1 | Pulse from update logic when an update completes |
| alarm_hit_i | input | 1 | Pulse from alarm comparator on a match |
| rate_sel_i | input | 4 | Periodic rate code (0 = off) |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| upd_en_i | input | 1 | Update-complete interrupt enable |
| flag_rd_i | input | 1 | Flag byte read strobe, clears flags at edge |
| flags_o | output | 8 | Flag byte {irq, periodic, alarm, update, 4'b0} |
| irq_n_o | output | 1 | Shared interrupt, active low |

## Verification
An event pulse, a read strobe or the tick that completes a periodic interval changes the flags one clock edge later. The bench drives every input at a falling edge and samples at the following falling edge, after the one rising edge between them. An enable change reaches bit 7 and the pin with no register in the path. The bench therefore samples one time unit after it changes the enable, inside the same cycle. For the periodic interval, the bench applies one tick fewer than the period and checks that the flag is still clear. It then applies the last tick and checks that the flag is set, which fixes the exact tick count.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, source indices and rate-code decoding for the
// RTC interrupt controller. Assumes a 32.768 kHz timebase tick.
package rtc_irq_pkg;

    localparam int CNT_W  = 15;  // divider width, enough for the slowest rate
    localparam int SEL_W  = 4;   // rate code width
    localparam int EXP_W  = 4;   // width of a period exponent (0..14)
    localparam int NSRC   = 3;   // number of interrupt sources
    localparam int BYTE_W = 8;   // flag byte width
    localparam int FLAG_LSB = 4; // byte bit of source index 0

    // Source index; byte bit = FLAG_LSB + index.
    typedef enum logic [1:0] {
        SRC_UPD = 2'd0,
        SRC_ALM = 2'd1,
        SRC_PER = 2'd2
    } src_idx_e;

    // Map a rate code to the log2 of the periodic interval in ticks.
    // Zero means the periodic source is off.
    function automatic logic [EXP_W-1:0] rate_exp(input logic [SEL_W-1:0] sel);
        logic [EXP_W-1:0] e;
        case (sel)
            4'd0:    e = 4'd0;
            4'd1:    e = 4'd7;
            4'd2:    e = 4'd8;
            default: e = EXP_W'(sel - 4'd1);
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rtc_rate_div.sv
`timescale 1ns/1ps
// Module: periodic rate divider. It counts timebase ticks in a free-running
// counter and emits a one-cycle pulse on the tick that completes each
// interval of 2^e ticks, where e comes from the rate code.
// Assumes tick_i is high for one clock cycle per timebase period.
module rtc_rate_div
    import rtc_irq_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [SW-1:0] rate_sel_i,
    output logic          pulse_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0]    cnt_q;
    logic [EXP_W-1:0] exp_w;
    logic [CW-1:0]    mask_w;

    // Advance the tick counter on every timebase tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + ONE;
    end

    // Decode the interval and fire on the tick that fills the low bits.
    always_comb begin
        exp_w   = rate_exp(rate_sel_i);
        mask_w  = (ONE << exp_w) - ONE;
        pulse_o = tick_i && (exp_w != '0) && ((cnt_q & mask_w) == mask_w);
    end

endmodule

// File: rtl/rtc_flag_cell.sv
`timescale 1ns/1ps
// Module: one sticky event flag. An event sets it. A read clears it unless an
// event arrives in the same cycle, in which case that event is kept.
module rtc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold the flag; a read replaces it with this cycle's event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (clr_i)
            flag_o <= set_i;
        else
            flag_o <= flag_o | set_i;
    end

endmodule

// File: rtl/rtc_irq_merge.sv
`timescale 1ns/1ps
// Module: combines flags and enables into the flag byte and the active-low
// interrupt pin. Purely combinational, so enables act in the same cycle.
module rtc_irq_merge
    import rtc_irq_pkg::*;
#(
    parameter int NS = NSRC
) (
    input  logic [NS-1:0]     flags_i,
    input  logic [NS-1:0]     en_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              irq_n_o
);

    logic req_w;

    // Build the summary bit, the source bits and the pin level.
    always_comb begin
        req_w  = |(flags_i & en_i);
        byte_o = '0;
        for (int i = 0; i < NS; i++)
            byte_o[FLAG_LSB + i] = flags_i[i];
        byte_o[BYTE_W-1] = req_w;
        irq_n_o = ~req_w;
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
// Module: top of the RTC interrupt controller. It connects the periodic
// divider, one flag cell per source and the output merge.
// Assumes event pulses and read strobe are synchronous to clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              update_done_i,
    input  logic              alarm_hit_i,
    input  logic [SEL_W-1:0]  rate_sel_i,
    input  logic              per_en_i,
    input  logic              alm_en_i,
    input  logic              upd_en_i,
    input  logic              flag_rd_i,
    output logic [BYTE_W-1:0] flags_o,
    output logic              irq_n_o
);

    logic            per_pulse_w;
    logic [NSRC-1:0] evt_w;
    logic [NSRC-1:0] en_w;
    logic [NSRC-1:0] flag_w;

    rtc_rate_div #(.CW(CNT_W), .SW(SEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .rate_sel_i(rate_sel_i),
        .pulse_o   (per_pulse_w)
    );

    // Gather events and enables in source-index order.
    always_comb begin
        evt_w          = '0;
        en_w           = '0;
        evt_w[SRC_UPD] = update_done_i;
        evt_w[SRC_ALM] = alarm_hit_i;
        evt_w[SRC_PER] = per_pulse_w;
        en_w[SRC_UPD]  = upd_en_i;
        en_w[SRC_ALM]  = alm_en_i;
        en_w[SRC_PER]  = per_en_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        rtc_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_w[g]),
            .clr_i (flag_rd_i),
            .flag_o(flag_w[g])
        );
    end

    rtc_irq_merge #(.NS(NSRC)) u_merge (
        .flags_i(flag_w),
        .en_i   (en_w),
        .byte_o (flags_o),
        .irq_n_o(irq_n_o)
    );

endmodule

// File: rtl/rtc_irq_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the RTC interrupt controller ports.
module rtc_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       update_done_i,
    input logic       alarm_hit_i,
    input logic [3:0] rate_sel_i,
    input logic       flag_rd_i,
    input logic [7:0] flags_o,
    input logic       irq_n_o
);

    // R6
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[3:0] == 4'h0);

    // R7
    pin_tracks_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !flags_o[7]);

    // R5
    alarm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit_i |=> flags_o[5]);

    // R5
    update_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_done_i |=> flags_o[4]);

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd_i && !alarm_hit_i && !update_done_i && !tick_i)
        |=> (flags_o[6:4] == 3'b000) && irq_n_o);

    // R9
    read_keeps_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd_i && alarm_hit_i) |=> flags_o[5]);

    // R10
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_rd_i && flags_o[5]) |=> flags_o[5]);

    // R4
    rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel_i == 4'd0 && !flags_o[6]) |=> !flags_o[6]);

    // R11
    no_tick_no_periodic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !flags_o[6]) |=> !flags_o[6]);

endmodule

bind rtc_irq_ctrl rtc_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .update_done_i(update_done_i),
    .alarm_hit_i  (alarm_hit_i),
    .rate_sel_i   (rate_sel_i),
    .flag_rd_i    (flag_rd_i),
    .flags_o      (flags_o),
    .irq_n_o      (irq_n_o)
);

// File: tb/tb_rtc_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: walks a table of rate codes and interval lengths, then runs
// directed tests of reset, flags, masking, read-clear and corner cases.
module tb_rtc_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    localparam logic [3:0] VSEL [0:NVEC-1] = '{
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
        4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
    localparam int VPER [0:NVEC-1] = '{
        128, 256, 4, 8, 16, 32, 64, 128,
        256, 512, 1024, 2048, 4096, 8192, 16384};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       update_done_i = 1'b0;
    logic       alarm_hit_i = 1'b0;
    logic [3:0] rate_sel_i = 4'd0;
    logic       per_en_i = 1'b0;
    logic       alm_en_i = 1'b0;
    logic       upd_en_i = 1'b0;
    logic       flag_rd_i = 1'b0;
    logic [7:0] flags_o;
    logic       irq_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .update_done_i(update_done_i),
        .alarm_hit_i  (alarm_hit_i),
        .rate_sel_i   (rate_sel_i),
        .per_en_i     (per_en_i),
        .alm_en_i     (alm_en_i),
        .upd_en_i     (upd_en_i),
        .flag_rd_i    (flag_rd_i),
        .flags_o      (flags_o),
        .irq_n_o      (irq_n_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick_once();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", flags_o, 8'h00);
        chk("R1 pin in reset", {7'd0, irq_n_o}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", flags_o, 8'h00);

        // Table walk: R2 and R3 interval length per rate code.
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            rate_sel_i = VSEL[v];
            for (int t = 0; t < VPER[v] - 1; t++) tick_once();
            chk((VSEL[v] < 3) ? "R3 before interval" : "R2 before interval", flags_o, 8'h00);
            tick_once();
            chk((VSEL[v] < 3) ? "R3 at interval" : "R2 at interval", flags_o, 8'h40);
        end

        // R4: rate code 0 never sets the periodic flag.
        do_reset();
        rate_sel_i = 4'd0;
        per_en_i = 1'b1;
        for (int t = 0; t < 300; t++) tick_once();
        chk("R4 rate off flags", flags_o, 8'h00);
        chk("R4 rate off pin", {7'd0, irq_n_o}, 8'h01);
        per_en_i = 1'b0;

        // R11: no ticks, no periodic flag even at the fastest code.
        do_reset();
        rate_sel_i = 4'd3;
        repeat (20) @(negedge clk);
        chk("R11 no tick", flags_o, 8'h00);
        rate_sel_i = 4'd0;

        // R5, R6, R7: flags set while masked.
        pulse(alarm_hit_i);
        chk("R5 alarm masked", flags_o, 8'h20);
        chk("R7 pin masked", {7'd0, irq_n_o}, 8'h01);
        pulse(update_done_i);
        chk("R6 alarm+update", flags_o, 8'h30);
        @(negedge clk) alm_en_i = 1'b1;
        #1;
        chk("R7 enable summary", flags_o, 8'hB0);
        chk("R7 enable pin", {7'd0, irq_n_o}, 8'h00);

        // R10: sticky.
        repeat (10) @(negedge clk);
        chk("R10 sticky", flags_o, 8'hB0);

        // R8: read clears.
        @(negedge clk) flag_rd_i = 1'b1;
        @(negedge clk) flag_rd_i = 1'b0;
        chk("R8 cleared", flags_o, 8'h00);
        chk("R8 pin released", {7'd0, irq_n_o}, 8'h01);

        // R9: event with read is kept.
        @(negedge clk) begin flag_rd_i = 1'b1; update_done_i = 1'b1; end
        @(negedge clk) begin flag_rd_i = 1'b0; update_done_i = 1'b0; end
        chk("R9 kept", flags_o, 8'h10);
        upd_en_i = 1'b1;
        #1;
        chk("R9 kept enabled", flags_o, 8'h90);
        chk("R7 update pin", {7'd0, irq_n_o}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule